// File: doc/BRIEF.md
# Reference-aligned frame and multiframe timer

This block derives frame-rate and multiframe-rate timing from one device clock that runs at an integer multiple of the frame rate. A free-running device-phase counter divides the device clock by a programmed ratio. A second counter tracks the frame position inside a multiframe. Strobes are decoded from both counters, so no separate frame clock is needed.

An active-high timing reference pulse re-phases both counters. The block registers the pulse through two stages and reduces it to one event per rising edge. The event then forces both counters onto a common boundary. The alignment therefore lands a fixed number of device-clock cycles after the pulse. This holds on every power-up and every resynchronisation, so the latency counted in frame periods stays the same.

The reference may be used as a single strobe or as a continuous or gapped pulse train. After alignment the block raises a done flag. It also issues a one-cycle release strobe on the first aligned multiframe boundary, which tells downstream receive buffers they may start reading.

Top module: `ref_aligned_frame_timer`

## Requirements
- R1: While rst_ni is low and just after it is released, dev_phase_o and frame_idx_o are 0, and done_o, rel_o and phase_err_o are 0.
- R2: dev_phase_o steps by one on every device clock edge and wraps to 0 after reaching the effective ratio minus one. frame_tick_o is high exactly when dev_phase_o is 0. The effective ratio is ratio_i limited to the range 2..8: values 0 and 1 act as 2, and values above 8 act as 8.
- R3: frame_idx_o steps by one on each edge at which dev_phase_o wraps, and itself wraps after reaching the effective frame count minus one. mf_tick_o is high exactly when both counters are 0. The effective frame count is frames_i limited to the range 1..32: 0 acts as 1, and values above 32 act as 32.
- R4: If ref_i is first seen high at device clock edge k, and was low at edge k-1, an accepted event makes dev_phase_o and frame_idx_o equal 0 after edge k+2. A level held high for several cycles yields one event.
- R5: With mode_i = 1 (single), only the first event after enabling aligns the counters. Later events have no effect on the counters or on phase_err_o until ref_en_i has been low for at least one edge.
- R6: With mode_i = 0 (continuous or gapped), every event is checked. If the counters would wrap to 0 at that edge anyway, nothing changes. Otherwise the counters realign, and, if an alignment was already accepted since enabling, phase_err_o is high for the one cycle after that edge.
- R7: While ref_en_i is low at an edge, events are ignored and the aligned state and done_o are cleared. The counters keep running.
- R8: done_o rises on the edge that ends the first multiframe-boundary cycle after an accepted alignment. It stays high until reset or until ref_en_i goes low.
- R9: rel_o is a one-cycle strobe during the first multiframe-boundary cycle after an accepted alignment, which is the cycle just before done_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | device clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| ref_i | input | 1 | active-high timing reference pulse |
| ref_en_i | input | 1 | accept reference events; low re-arms |
| mode_i | input | 1 | 0 continuous or gapped, 1 single strobe |
| ratio_i | input | 4 | device clocks per frame (2..8) |
| frames_i | input | 6 | frames per multiframe (1..32) |
| frame_tick_o | output | 1 | first device cycle of a frame |
| mf_tick_o | output | 1 | first device cycle of a multiframe |
| dev_phase_o | output | 3 | device cycle within the frame |
| frame_idx_o | output | 5 | frame within the multiframe |
| done_o | output | 1 | alignment complete |
| rel_o | output | 1 | receive buffer read release strobe |
| phase_err_o | output | 1 | continuous-mode event arrived off phase |

## Verification
The properties assume that ratio_i, frames_i and mode_i hold steady while the timer runs. A change of ratio in mid-frame would break the phase-step property. The stimulus therefore changes configuration only while rst_ni is low. It also drives ref_i, ref_en_i and mode_i at the falling edge, so each value is settled before the rising edge that samples it. The stimulus sweeps ratio settings 1 through 9 against frame counts 0, 1, 2, 5, 32 and 33, which covers every clamp on both settings. In continuous mode it times the reference pulses to land both on phase zero and off it.

// File: rtl/rft_pkg.sv
package rft_pkg;
  typedef enum logic {
    REF_CONT   = 1'b0,
    REF_SINGLE = 1'b1
  } ref_mode_e;
endpackage

// File: rtl/rft_ref_capture.sv
module rft_ref_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic evt_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], ref_i};
  end

  // rising edge at the end of the register chain
  assign evt_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/rft_wrap_counter.sv
module rft_wrap_counter #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         load_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         at_last_o
);
  logic [W-1:0] cnt_q;

  assign at_last_o = (cnt_q >= last_i);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= '0;
    else if (adv_i)  cnt_q <= at_last_o ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/rft_align_ctrl.sv
module rft_align_ctrl
  import rft_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      evt_i,
  input  logic      en_i,
  input  ref_mode_e mode_i,
  input  logic      at_wrap_i,
  input  logic      mf_tick_i,
  output logic      align_o,
  output logic      done_o,
  output logic      rel_o,
  output logic      err_o
);
  logic aligned_q, done_q, err_q;
  logic accept;

  assign accept  = evt_i & en_i & ((mode_i == REF_CONT) | ~aligned_q);
  // already on phase zero: the natural wrap does the job
  assign align_o = accept & ~at_wrap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else if (!en_i) begin
      aligned_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= accept & (mode_i == REF_CONT) & aligned_q & ~at_wrap_i;
      if (accept)                 aligned_q <= 1'b1;
      if (mf_tick_i && aligned_q) done_q    <= 1'b1;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
  assign rel_o  = mf_tick_i & aligned_q & ~done_q;
endmodule

// File: rtl/ref_aligned_frame_timer.sv
module ref_aligned_frame_timer
  import rft_pkg::*;
#(
  parameter int MIN_RATIO   = 2,
  parameter int MAX_RATIO   = 8,
  parameter int MAX_FRAMES  = 32,
  parameter int SYNC_STAGES = 2,
  localparam int RATIO_W    = $clog2(MAX_RATIO + 1),
  localparam int PH_W       = $clog2(MAX_RATIO),
  localparam int FRM_W      = $clog2(MAX_FRAMES + 1),
  localparam int IDX_W      = $clog2(MAX_FRAMES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_i,
  input  logic               ref_en_i,
  input  logic               mode_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [FRM_W-1:0]   frames_i,
  output logic               frame_tick_o,
  output logic               mf_tick_o,
  output logic [PH_W-1:0]    dev_phase_o,
  output logic [IDX_W-1:0]   frame_idx_o,
  output logic               done_o,
  output logic               rel_o,
  output logic               phase_err_o
);
  logic [RATIO_W-1:0] ratio_eff;
  logic [FRM_W-1:0]   frames_eff;
  logic [PH_W-1:0]    ph_last;
  logic [IDX_W-1:0]   idx_last;
  logic               ph_at_last, idx_at_last;
  logic               ref_evt, align_now;
  ref_mode_e          mode;

  always_comb begin
    if (ratio_i < RATIO_W'(MIN_RATIO))      ratio_eff = RATIO_W'(MIN_RATIO);
    else if (ratio_i > RATIO_W'(MAX_RATIO)) ratio_eff = RATIO_W'(MAX_RATIO);
    else                                    ratio_eff = ratio_i;
    if (frames_i == '0)                      frames_eff = FRM_W'(1);
    else if (frames_i > FRM_W'(MAX_FRAMES)) frames_eff = FRM_W'(MAX_FRAMES);
    else                                    frames_eff = frames_i;
  end

  assign ph_last  = PH_W'(ratio_eff - RATIO_W'(1));
  assign idx_last = IDX_W'(frames_eff - FRM_W'(1));
  assign mode     = ref_mode_e'(mode_i);

  rft_ref_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ref_i (ref_i),
    .evt_o (ref_evt)
  );

  rft_wrap_counter #(.W(PH_W)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (1'b1),
    .load_i   (align_now),
    .last_i   (ph_last),
    .cnt_o    (dev_phase_o),
    .at_last_o(ph_at_last)
  );

  rft_wrap_counter #(.W(IDX_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (ph_at_last),
    .load_i   (align_now),
    .last_i   (idx_last),
    .cnt_o    (frame_idx_o),
    .at_last_o(idx_at_last)
  );

  assign frame_tick_o = (dev_phase_o == '0);
  assign mf_tick_o    = frame_tick_o & (frame_idx_o == '0);

  rft_align_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (ref_evt),
    .en_i     (ref_en_i),
    .mode_i   (mode),
    .at_wrap_i(ph_at_last & idx_at_last),
    .mf_tick_i(mf_tick_o),
    .align_o  (align_now),
    .done_o   (done_o),
    .rel_o    (rel_o),
    .err_o    (phase_err_o)
  );
endmodule

// File: rtl/rft_checker.sv
module rft_checker #(
  parameter int PH_W  = 3,
  parameter int IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             ref_en_i,
  input logic             frame_tick_o,
  input logic             mf_tick_o,
  input logic [PH_W-1:0]  dev_phase_o,
  input logic [IDX_W-1:0] frame_idx_o,
  input logic             done_o,
  input logic             rel_o,
  input logic             phase_err_o,
  input logic             align_now,
  input logic             ref_evt
);
  // R2
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !align_now |=> (dev_phase_o == '0 || int'(dev_phase_o) == int'($past(dev_phase_o)) + 1));
  // R3
  mf_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_tick_o |-> frame_tick_o);
  // R4
  align_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_now |=> (dev_phase_o == '0 && frame_idx_o == '0));
  // R4
  evt_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_evt |=> !ref_evt);
  // R6
  err_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_err_o |-> ($past(mode_i) == 1'b0));
  // R7
  en_low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_en_i |=> (!done_o && !phase_err_o));
  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ref_en_i) |=> done_o);
  // R9
  rel_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_o |-> (mf_tick_o && !done_o));
  // R9
  rel_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_o |=> !rel_o);
endmodule

bind ref_aligned_frame_timer rft_checker #(.PH_W(PH_W), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .ref_en_i    (ref_en_i),
  .frame_tick_o(frame_tick_o),
  .mf_tick_o   (mf_tick_o),
  .dev_phase_o (dev_phase_o),
  .frame_idx_o (frame_idx_o),
  .done_o      (done_o),
  .rel_o       (rel_o),
  .phase_err_o (phase_err_o),
  .align_now   (align_now),
  .ref_evt     (ref_evt)
);

// File: tb/ref_aligned_frame_timer_test.sv
module ref_aligned_frame_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_d = 1'b0, en_d = 1'b0, mode_d = 1'b0;
  logic [3:0] ratio_d = 4'd2;
  logic [5:0] frames_d = 6'd1;
  logic       frame_tick, mf_tick, done, rel, perr;
  logic [2:0] phase;
  logic [4:0] idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_aligned_frame_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_d), .ref_en_i(en_d), .mode_i(mode_d),
    .ratio_i(ratio_d), .frames_i(frames_d), .frame_tick_o(frame_tick), .mf_tick_o(mf_tick),
    .dev_phase_o(phase), .frame_idx_o(idx), .done_o(done), .rel_o(rel), .phase_err_o(perr)
  );

  int checks = 0, errors = 0;
  int n, a, R, K, P;
  bit aligned_m, done_m, err_m, ref_last, ev1, ev2;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d (edge %0d)", req, what, act, exp, n);
    end
  endtask

  task automatic compare(string ctx);
    int ph, ix;
    ph = (n - a) % R;
    ix = ((n - a) / R) % K;
    chk({"R2 ", ctx}, "dev_phase", int'(phase), ph);
    chk("R2", "frame_tick", int'(frame_tick), int'(ph == 0));
    chk({"R3 ", ctx}, "frame_idx", int'(idx), ix);
    chk("R3", "mf_tick", int'(mf_tick), int'(ph == 0 && ix == 0));
    chk("R8", "done", int'(done), int'(done_m));
    chk("R9", "rel", int'(rel), int'(aligned_m && !done_m && ph == 0 && ix == 0));
    chk({"R6 ", ctx}, "phase_err", int'(perr), int'(err_m));
  endtask

  task automatic step(string ctx);
    bit apply, al_prev, bnd_prev;
    @(posedge clk);
    n++;
    apply    = ev2;
    ev2      = ev1;
    ev1      = ref_d && !ref_last;
    ref_last = ref_d;
    bnd_prev = ((n - 1 - a) % P) == 0;
    al_prev  = aligned_m;
    err_m    = 1'b0;
    if (!en_d) begin
      aligned_m = 1'b0;
      done_m    = 1'b0;
    end else begin
      if (al_prev && bnd_prev) done_m = 1'b1;
      if (apply && (!mode_d || !al_prev)) begin
        if (((n - a) % P) != 0) begin
          if (!mode_d && al_prev) err_m = 1'b1;
          a = n;
        end
        aligned_m = 1'b1;
      end
    end
    @(negedge clk);
    compare(ctx);
  endtask

  task automatic run(int cyc, string ctx);
    for (int i = 0; i < cyc; i++) step(ctx);
  endtask

  task automatic pulse(int len, string ctx);
    ref_d = 1'b1;
    run(len, ctx);
    ref_d = 1'b0;
  endtask

  // next sample edge puts the applying edge at phase offset off
  task automatic wait_offset(int off, string ctx);
    while (((n + 3 - a) % P) != off) step(ctx);
  endtask

  task automatic do_reset(int rr, int kk, bit md);
    @(negedge clk);
    rst_n = 1'b0; ref_d = 1'b0; en_d = 1'b1; mode_d = md;
    ratio_d = 4'(rr); frames_d = 6'(kk);
    R = (rr < 2) ? 2 : (rr > 8) ? 8 : rr;
    K = (kk < 1) ? 1 : (kk > 32) ? 32 : kk;
    P = R * K;
    n = 0; a = 0; aligned_m = 0; done_m = 0; err_m = 0; ref_last = 0; ev1 = 0; ev2 = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
  endtask

  int klist[6] = '{0, 1, 2, 5, 32, 33};

  initial begin
    do_reset(4, 3, 1'b0);
    chk("R1", "phase after reset", int'(phase), 0);
    chk("R1", "done after reset", int'(done), 0);
    for (int ri = 1; ri <= 9; ri++) begin
      foreach (klist[ki]) begin
        // continuous and gapped use
        do_reset(ri, klist[ki], 1'b0);
        run(7, "R2");
        pulse(1, "R4");
        run(P + 3, "R4");
        pulse(4, "R4");
        run(2 * P + 2, "R8");
        for (int j = 0; j < 3; j++) begin
          wait_offset(0, "R6");
          pulse(1, "R6");
        end
        run(2 * P + 1, "R6");
        wait_offset(0, "R6");
        pulse(1, "R6");
        wait_offset(1 % P, "R6");
        pulse(1, "R6");
        run(P + 4, "R6");
        en_d = 1'b0;
        pulse(1, "R7");
        run(P + 4, "R7");
        en_d = 1'b1;
        run(3, "R7");
        // single strobe use
        do_reset(ri, klist[ki], 1'b1);
        run(5, "R5");
        pulse(2, "R5");
        run(P + 4, "R5");
        wait_offset(1 % P, "R5");
        pulse(1, "R5");
        run(P + 4, "R5");
        en_d = 1'b0;
        run(2, "R7");
        en_d = 1'b1;
        wait_offset(1 % P, "R5");
        pulse(1, "R5");
        run(P + 4, "R9");
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule